// File: doc/BRIEF.md
# Double-Buffered Serial Byte Datapath

This block is the byte path behind a two-wire serial port. Software loads outgoing bytes into a holding register; the holding register refills an internal shift register whenever the shifter is free, so several bytes can leave with no gap between them. Incoming bits enter the same shift register. When the byte-complete pulse arrives, the finished byte moves into a read-only receive register, and the shifter is free to take the next byte at once.

An address register holds a seven-bit device address and a format bit. A mode register selects bit order and slave operation. In slave mode with bus format, the first byte received after each start pulse is compared with the stored address. The result is held as a match flag until the next start pulse. Bit timing, acknowledge, arbitration and pin drive are handled outside the block. The block only shifts when the shift strobe is asserted.

Top module: `sbyte_path`

## Requirements
- R1: After reset the address register reads 0x00, the mode register 0x00, the transmit holding register 0xFF and the receive register 0xFF. tx_empty is 1, rx_full is 0, addr_match is 0, and ser_out idles at 1.
- R2: A CPU write to select 1 (transmit) clears tx_empty on the next edge. If the shifter is idle, the byte moves into the shifter one edge later, tx_empty returns to 1, and ser_out presents the first bit.
- R3: With mode bit 0 (bit order) at 0, bits leave most significant first. Each shift strobe advances ser_out by one bit.
- R4: A byte written while the shifter is still sending is held. On the byte-complete pulse it moves into the shifter on the same edge, so its first bit appears on the next cycle with no idle gap.
- R5: With mode bit 0 at 1, a byte written to the transmit register reads back bit-reversed and is sent least significant bit first.
- R6: On byte_done the shifted-in bits are copied to the receive register, with the first bit received as bit 7, or as bit 0 when mode bit 0 is 1. rx_full is set on that same edge and cleared by a CPU read of select 2.
- R7: A CPU write to select 2 leaves the receive register unchanged.
- R8: With mode bit 1 (slave) at 1 and address bit 0 (format) at 0, addr_match goes high after byte_done only if bits 7..1 of the first received byte after a start pulse equal address bits 7..1.
- R9: addr_match changes only on start_pulse, which clears it, or on the first byte_done after a start. Bytes that follow do not alter it.
- R10: When the format bit is 1 or slave mode is off, addr_match stays 0.
- R11: The address register reads back the value written, including the format bit. Select 0 is the address register and select 3 is the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (clears rx_full on select 2) |
| cpu_sel | input | 2 | Register select: 0 address, 1 transmit, 2 receive, 3 mode |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data for the selected register |
| shift_en | input | 1 | Shift one bit |
| ser_in | input | 1 | Serial data in |
| start_pulse | input | 1 | Start condition seen |
| byte_done | input | 1 | Eight bits have been shifted |
| ser_out | output | 1 | Serial data out |
| addr_match | output | 1 | Address matched this transfer |
| tx_empty | output | 1 | Holding register free |
| rx_full | output | 1 | Receive register holds unread data |

## Verification
The hardest case to reach is the refill on the byte-complete edge. It needs a second byte written while the first is still partway through its shifts. The stimulus writes the second byte after three shift strobes and then checks the bit on the very next cycle after byte_done. Every byte value is looped from ser_out back into ser_in in both bit orders. All 256 first-byte values are swept against a fixed address, and the match decision is then checked again against follow-on bytes.

// File: rtl/sbyte_path.sv
module sbyte_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [1:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          shift_en,
  input  logic          ser_in,
  input  logic          start_pulse,
  input  logic          byte_done,
  output logic          ser_out,
  output logic          addr_match,
  output logic          tx_empty,
  output logic          rx_full
);
  localparam logic [1:0] SEL_ADR = 2'd0;
  localparam logic [1:0] SEL_TX = 2'd1;
  localparam logic [1:0] SEL_RX = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;
  localparam logic [DW-1:0] ONES = '1;

  logic [DW-1:0] adr_q, hold_q, rx_q, sh_q;
  logic [1:0]    mode_q;
  logic          pend_q, idle_q, first_q, match_q, full_q;

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
    return r;
  endfunction

  wire lsb_first = mode_q[0];
  wire slave_en  = mode_q[1];
  wire fmt_sync  = adr_q[0];
  wire wr_tx     = cpu_wr && cpu_sel == SEL_TX;
  wire rd_rx     = cpu_rd && cpu_sel == SEL_RX;
  wire load      = pend_q && (idle_q || byte_done) && !wr_tx;
  wire [DW-1:0] rx_next = lsb_first ? flip(sh_q) : sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q  <= '0;
      mode_q <= '0;
      hold_q <= ONES;
    end else if (cpu_wr) begin
      case (cpu_sel)
        SEL_ADR:  adr_q  <= cpu_wdata;
        SEL_TX:   hold_q <= lsb_first ? flip(cpu_wdata) : cpu_wdata;
        SEL_MODE: mode_q <= cpu_wdata[1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= ONES;
      idle_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (load) sh_q <= hold_q;
      else if (shift_en && !byte_done) sh_q <= {sh_q[DW-2:0], ser_in};
      if (load) idle_q <= 1'b0;
      else if (byte_done) idle_q <= 1'b1;
      if (wr_tx) pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= ONES;
      full_q <= 1'b0;
    end else begin
      if (byte_done) rx_q <= rx_next;
      if (byte_done) full_q <= 1'b1;
      else if (rd_rx) full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      match_q <= 1'b0;
    end else if (start_pulse) begin
      first_q <= 1'b1;
      match_q <= 1'b0;
    end else if (byte_done && first_q) begin
      first_q <= 1'b0;
      match_q <= rx_next[DW-1:1] == adr_q[DW-1:1];
    end
  end

  always_comb begin
    case (cpu_sel)
      SEL_ADR: cpu_rdata = adr_q;
      SEL_TX:  cpu_rdata = hold_q;
      SEL_RX:  cpu_rdata = rx_q;
      default: cpu_rdata = {{(DW-2){1'b0}}, mode_q};
    endcase
  end

  assign ser_out    = idle_q ? 1'b1 : sh_q[DW-1];
  assign addr_match = match_q && slave_en && !fmt_sync;
  assign tx_empty   = !pend_q;
  assign rx_full    = full_q;
endmodule

// File: rtl/sbyte_path_chk.sv
module sbyte_path_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [1:0]    cpu_sel,
  input logic          start_pulse,
  input logic          byte_done,
  input logic          idle_q,
  input logic [DW-1:0] rx_q,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          addr_match
);
  // R2
  tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_sel == 2'd1 |=> !tx_empty);
  // R2
  tx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty && idle_q && !(cpu_wr && cpu_sel == 2'd1) |=> tx_empty);
  // R6
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rx_full);
  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_sel == 2'd2 && !byte_done |=> !rx_full);
  // R7
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rx_q));
  // R9
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse && !byte_done && !cpu_wr |=> $stable(addr_match));
  // R9
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !addr_match);
endmodule

bind sbyte_path sbyte_path_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
  .start_pulse(start_pulse), .byte_done(byte_done), .idle_q(idle_q), .rx_q(rx_q),
  .tx_empty(tx_empty), .rx_full(rx_full), .addr_match(addr_match)
);

// File: tb/test_sbyte_path.sv
module test_sbyte_path;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0, cpu_rd = 0, shift_en = 0, ser_in = 0, start_pulse = 0, byte_done = 0;
  logic [1:0] cpu_sel = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic ser_out, addr_match, tx_empty, rx_full;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  sbyte_path i_sbyte_path (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .shift_en(shift_en), .ser_in(ser_in),
    .start_pulse(start_pulse), .byte_done(byte_done), .ser_out(ser_out),
    .addr_match(addr_match), .tx_empty(tx_empty), .rx_full(rx_full));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cpu_sel = s; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); cpu_sel = s; cpu_rd = 1; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic shift1(input logic b);
    ser_in = b; shift_en = 1;
    @(negedge clk); shift_en = 0;
  endtask

  task automatic done1;
    byte_done = 1;
    @(negedge clk); byte_done = 0;
  endtask

  task automatic start1;
    @(negedge clk); start_pulse = 1;
    @(negedge clk); start_pulse = 0;
  endtask

  task automatic recv(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift1(v[i]);
    done1();
  endtask

  task automatic loop_byte(input logic [7:0] b, input bit lsb);
    logic [7:0] seen, got;
    wr(2'd1, b);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (lsb) seen[i] = ser_out; else seen[7-i] = ser_out;
      shift1(ser_out);
    end
    done1();
    chk(lsb ? "R5 serial order" : "R3 serial order", seen, b);
    rd(2'd2, got);
    chk("R6 loopback rx", got, b);
  endtask

  initial begin
    #(PERIOD*200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog got timeout exp finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 adr", v, 8'h00);
    rd(2'd3, v); chk("R1 mode", v, 8'h00);
    rd(2'd1, v); chk("R1 hold", v, 8'hFF);
    chk("R1 flags", {4'b0, tx_empty, rx_full, addr_match, ser_out}, 8'b0000_1001);
    rd(2'd2, v); chk("R1 rx", v, 8'hFF);

    // R11 address register readback
    wr(2'd0, 8'hA7); rd(2'd0, v); chk("R11 adr", v, 8'hA7);

    // R2 timing of tx_empty and load
    @(negedge clk); cpu_sel = 2'd1; cpu_wdata = 8'h96; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
    chk("R2 empty low", {7'b0, tx_empty}, 8'd0);
    @(negedge clk);
    chk("R2 empty high", {7'b0, tx_empty}, 8'd1);
    chk("R2 first bit", {7'b0, ser_out}, 8'd1);
    for (int i = 0; i < 8; i++) shift1(ser_out);
    done1();
    chk("R6 full set", {7'b0, rx_full}, 8'd1);
    rd(2'd2, v); chk("R6 rx", v, 8'h96);
    chk("R6 full clear", {7'b0, rx_full}, 8'd0);

    // R7 write to receive register ignored
    wr(2'd2, 8'h3C); rd(2'd2, v); chk("R7 rx unchanged", v, 8'h96);

    // R3 and R6 sweep, MSB first
    for (int b = 0; b < 256; b++) loop_byte(b[7:0], 1'b0);
    // R5 readback and LSB-first sweep
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h2C); rd(2'd1, v); chk("R5 readback", v, rev8(8'h2C));
    @(negedge clk);
    for (int i = 0; i < 8; i++) shift1(ser_out);
    done1(); rd(2'd2, v);
    for (int b = 0; b < 256; b++) loop_byte(b[7:0], 1'b1);
    wr(2'd3, 8'h00);

    // R4 back-to-back refill
    wr(2'd1, 8'hC3); @(negedge clk);
    for (int i = 0; i < 3; i++) shift1(ser_out);
    wr(2'd1, 8'h5A);
    chk("R4 queued", {7'b0, tx_empty}, 8'd0);
    for (int i = 0; i < 5; i++) shift1(ser_out);
    done1();
    chk("R4 no gap bit", {7'b0, ser_out}, 8'd0);
    chk("R4 refilled", {7'b0, tx_empty}, 8'd1);
    for (int i = 0; i < 8; i++) begin
      v[7-i] = ser_out; shift1(ser_out);
    end
    done1();
    chk("R4 second byte", v, 8'h5A);
    rd(2'd2, v);

    // R8 sweep of first byte against address 0x5A
    wr(2'd3, 8'h02); wr(2'd0, 8'hB4);
    for (int b = 0; b < 256; b++) begin
      start1();
      chk("R9 start clears", {7'b0, addr_match}, 8'd0);
      recv(b[7:0]);
      chk("R8 match", {7'b0, addr_match}, {7'b0, b[7:1] == 7'h5A});
    end
    // R9 follow-on bytes do not change decision
    start1(); recv(8'hB5); recv(8'h00); recv(8'h11);
    chk("R9 hold match", {7'b0, addr_match}, 8'd1);
    start1(); recv(8'h02); recv(8'hB4);
    chk("R9 hold mismatch", {7'b0, addr_match}, 8'd0);
    // R10 format bit or slave off disables match
    wr(2'd0, 8'hB5);
    start1(); recv(8'hB4);
    chk("R10 sync format", {7'b0, addr_match}, 8'd0);
    wr(2'd0, 8'hB4); wr(2'd3, 8'h00);
    start1(); recv(8'hB4);
    chk("R10 slave off", {7'b0, addr_match}, 8'd0);
    wr(2'd3, 8'h02);
    chk("R8 slave on reveals", {7'b0, addr_match}, 8'd1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule